// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the write-only control port of a three-channel video digitiser. A host drives a serial clock, a serial data line and a load strobe. Each frame is fourteen bits: a 6-bit register address followed by an 8-bit data word, both sent most significant bit first, with one bit taken on every rising serial clock edge. A rising edge on the load strobe then commits the frame to the addressed register. All three serial lines are brought into the system clock domain by two-flop synchronisers, and their edges are detected there.

The register file holds four setup registers. It also holds three per-channel register groups: an 8-bit offset magnitude, a 1-bit offset sign and a 5-bit gain, one group each for red, green and blue. Each group has a fourth address that writes the same value to all three channels at once. Every field drives its own output port, so the analogue path can use the settings directly. A write of any data to the restore address returns every register to its power-on value.

Top module: `sercfg_port`

## Requirements
- R1: After reset the outputs are: converter enable 1, CDS enable 1, mono 0, fast-sync 0, invert 0, clamp select 01, reset timing 01, channel select 00, offset range 0. All offsets, signs and gains are 0.
- R2: A frame is the last 14 data bits sampled on rising serial clock edges before the strobe. The 6 address bits come first, then the 8 data bits, each MSB first. Any bits sent earlier than those 14 are discarded.
- R3: Address 0x01 sets converter enable from data bit 0, CDS enable from bit 1, mono from bit 2 and fast-sync from bit 6. Its other bits have no effect.
- R4: Address 0x02 sets the output invert flag from data bit 2. Its other bits have no effect.
- R5: Address 0x03 sets clamp select from data bits 1:0, reset timing from bits 5:4 and channel select from bits 7:6.
- R6: Address 0x05 sets the offset range flag from data bit 0.
- R7: The per-channel registers are indexed red=0, green=1, blue=2. Offset magnitudes are at 0x20 to 0x22 (8 bits). Offset signs are at 0x24 to 0x26 (data bit 0). Gains are at 0x28 to 0x2A (data bits 4:0). Writing one channel leaves the other two unchanged.
- R8: Addresses 0x23, 0x27 and 0x2B write the offset, the sign and the gain respectively to all three channels at once.
- R9: A write of any data value to address 0x04 restores every register to its R1 value.
- R10: A frame whose address has bit 4 set changes no register.
- R11: A strobe that arrives before 14 bits have been collected changes no register. Every strobe clears the bit count. A serial clock edge in the same cycle as the strobe becomes the first bit of the next frame.
- R12: A frame to an unassigned address with bit 4 clear (for example 0x00, 0x06 or 0x2C) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Commit strobe |
| conv_en | output | 1 | Converter enable |
| cds_en | output | 1 | Correlated double sampling enable |
| mono_en | output | 1 | Single-channel operation |
| fast_sync | output | 1 | Fast sync-rate flag |
| out_invert | output | 1 | Output code inversion |
| clamp_sel | output | 2 | Clamp voltage select |
| rst_timing | output | 2 | Reset-sample timing adjust |
| chan_sel | output | 2 | Channel picked in mono operation |
| offs_range | output | 1 | Offset range flag |
| offs_val | output | 24 | Offset magnitudes, red in bits 7:0 |
| offs_neg | output | 3 | Offset signs, red in bit 0 |
| gain | output | 15 | Gains, red in bits 4:0 |

## Verification
The strobe edge and a serial clock edge can be detected in the same system clock cycle. When they are, the strobe must commit the 14 bits already collected, and the new bit must be counted as bit one of the next frame. The bench sets up this case by raising the strobe and the serial clock in the same instant, after a complete frame. It then sends only 13 further bits and a strobe. The reference model expects both frames to land: the first at the earlier strobe, and the second with its MSB taken from the shared edge.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int FRAME = AW + DW;

  localparam logic [AW-1:0] A_SETUP1    = 6'h01;
  localparam logic [AW-1:0] A_SETUP2    = 6'h02;
  localparam logic [AW-1:0] A_SETUP3    = 6'h03;
  localparam logic [AW-1:0] A_RESTORE   = 6'h04;
  localparam logic [AW-1:0] A_SETUP4    = 6'h05;
  localparam logic [AW-1:0] A_OFFS_BASE = 6'h20;
  localparam logic [AW-1:0] A_SIGN_BASE = 6'h24;
  localparam logic [AW-1:0] A_GAIN_BASE = 6'h28;

  typedef struct packed {
    logic       conv_en;
    logic       cds_en;
    logic       mono_en;
    logic       fast_sync;
    logic       out_inv;
    logic [1:0] clamp;
    logic [1:0] rtime;
    logic [1:0] chan;
    logic       orange;
  } setup_t;

  localparam setup_t SETUP_DEF = '{conv_en: 1'b1, cds_en: 1'b1, mono_en: 1'b0,
                                   fast_sync: 1'b0, out_inv: 1'b0, clamp: 2'b01,
                                   rtime: 2'b01, chan: 2'b00, orange: 1'b0};
endpackage

// File: rtl/sercfg_rstsync.sv
module sercfg_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n   <= stage_q;
    end
  end
endmodule

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign q[i]    = s2_q;
    assign rise[i] = s2_q & ~s3_q;

    // R2: an edge is reported for exactly one cycle
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_rise,
  input  logic          bit_val,
  input  logic          load_rise,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int FRAME = AW + DW;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME);

  logic [FRAME-1:0] sr_q, sr_nx;
  logic [CW-1:0]    cnt_q, cnt_nx;

  always_comb begin
    sr_nx  = sr_q;
    cnt_nx = cnt_q;
    if (bit_rise) begin
      sr_nx  = {sr_q[FRAME-2:0], bit_val};
      cnt_nx = (cnt_q == FULL) ? cnt_q : cnt_q + CW'(1);
    end
    if (load_rise) begin
      cnt_nx = bit_rise ? CW'(1) : CW'(0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign wr_en   = load_rise && (cnt_q == FULL);
  assign wr_addr = sr_q[FRAME-1:DW];
  assign wr_data = sr_q[DW-1:0];

  // R2: the bit count never passes one frame
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R11: a strobe restarts the count, keeping at most a same-cycle bit
  p_cnt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> cnt_q <= CW'(1));
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int NCH = 3,
  parameter int GW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output setup_t          setup_q,
  output logic [NCH*DW-1:0] offs_val,
  output logic [NCH-1:0]    offs_neg,
  output logic [NCH*GW-1:0] gain
);
  localparam logic [AW-1:0] A_OFFS_ALL = A_OFFS_BASE + AW'(NCH);
  localparam logic [AW-1:0] A_SIGN_ALL = A_SIGN_BASE + AW'(NCH);
  localparam logic [AW-1:0] A_GAIN_ALL = A_GAIN_BASE + AW'(NCH);

  logic   restore, legal;
  setup_t setup_nx;

  assign restore = wr_en && (wr_addr == A_RESTORE);
  assign legal   = wr_en && !wr_addr[4];

  always_comb begin
    setup_nx = setup_q;
    if (restore) begin
      setup_nx = SETUP_DEF;
    end else if (legal) begin
      case (wr_addr)
        A_SETUP1: begin
          setup_nx.conv_en   = wr_data[0];
          setup_nx.cds_en    = wr_data[1];
          setup_nx.mono_en   = wr_data[2];
          setup_nx.fast_sync = wr_data[6];
        end
        A_SETUP2: setup_nx.out_inv = wr_data[2];
        A_SETUP3: begin
          setup_nx.clamp = wr_data[1:0];
          setup_nx.rtime = wr_data[5:4];
          setup_nx.chan  = wr_data[7:6];
        end
        A_SETUP4: setup_nx.orange = wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) setup_q <= SETUP_DEF;
    else        setup_q <= setup_nx;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam logic [AW-1:0] A_OFFS = A_OFFS_BASE + AW'(ch);
    localparam logic [AW-1:0] A_SIGN = A_SIGN_BASE + AW'(ch);
    localparam logic [AW-1:0] A_GAIN = A_GAIN_BASE + AW'(ch);

    logic [DW-1:0] ov_q, ov_nx;
    logic          sg_q, sg_nx;
    logic [GW-1:0] gn_q, gn_nx;
    logic          hit_ov, hit_sg, hit_gn;

    assign hit_ov = legal && ((wr_addr == A_OFFS) || (wr_addr == A_OFFS_ALL));
    assign hit_sg = legal && ((wr_addr == A_SIGN) || (wr_addr == A_SIGN_ALL));
    assign hit_gn = legal && ((wr_addr == A_GAIN) || (wr_addr == A_GAIN_ALL));

    always_comb begin
      ov_nx = ov_q;
      sg_nx = sg_q;
      gn_nx = gn_q;
      if (restore) begin
        ov_nx = '0;
        sg_nx = 1'b0;
        gn_nx = '0;
      end else begin
        if (hit_ov) ov_nx = wr_data;
        if (hit_sg) sg_nx = wr_data[0];
        if (hit_gn) gn_nx = wr_data[GW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ov_q <= '0;
        sg_q <= 1'b0;
        gn_q <= '0;
      end else begin
        ov_q <= ov_nx;
        sg_q <= sg_nx;
        gn_q <= gn_nx;
      end
    end

    assign offs_val[ch*DW +: DW] = ov_q;
    assign offs_neg[ch]          = sg_q;
    assign gain[ch*GW +: GW]     = gn_q;
  end

  // R10: an address with bit 4 set leaves every register untouched
  p_bit4_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[4]) |=> ($stable(setup_q) && $stable(offs_val) &&
                               $stable(offs_neg) && $stable(gain)));
  // R9: restore returns all state to its power-on value
  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_RESTORE)) |=> ((setup_q == SETUP_DEF) &&
      (offs_val == '0) && (offs_neg == '0) && (gain == '0)));
  // R8: a broadcast gain write leaves the channels equal
  p_bcast_gain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_GAIN_ALL)) |=> (gain == {NCH{gain[GW-1:0]}}));
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
  import sercfg_pkg::*;
(
  input  logic        clk,
  input  logic        arst_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_load,
  output logic        conv_en,
  output logic        cds_en,
  output logic        mono_en,
  output logic        fast_sync,
  output logic        out_invert,
  output logic [1:0]  clamp_sel,
  output logic [1:0]  rst_timing,
  output logic [1:0]  chan_sel,
  output logic        offs_range,
  output logic [23:0] offs_val,
  output logic [2:0]  offs_neg,
  output logic [14:0] gain
);
  localparam int NCH = 3;
  localparam int GW  = 5;

  logic          rst_n;
  logic [2:0]    lvl, rise;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  setup_t        setup;

  sercfg_rstsync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  sercfg_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_load, ser_dat, ser_clk}), .q(lvl), .rise(rise));

  sercfg_shift #(.AW(AW), .DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(rise[0]), .bit_val(lvl[1]), .load_rise(rise[2]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  sercfg_regs #(.NCH(NCH), .GW(GW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .setup_q(setup), .offs_val(offs_val), .offs_neg(offs_neg), .gain(gain));

  assign conv_en    = setup.conv_en;
  assign cds_en     = setup.cds_en;
  assign mono_en    = setup.mono_en;
  assign fast_sync  = setup.fast_sync;
  assign out_invert = setup.out_inv;
  assign clamp_sel  = setup.clamp;
  assign rst_timing = setup.rtime;
  assign chan_sel   = setup.chan;
  assign offs_range = setup.orange;
endmodule

// File: tb/test_sercfg_port.sv
module test_sercfg_port;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;
  logic conv_en, cds_en, mono_en, fast_sync, out_invert, offs_range;
  logic [1:0] clamp_sel, rst_timing, chan_sel;
  logic [23:0] offs_val;
  logic [2:0]  offs_neg;
  logic [14:0] gain;

  always #10 clk = ~clk;

  sercfg_port i_sercfg_port (
    .clk(clk), .arst_n(arst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .conv_en(conv_en), .cds_en(cds_en), .mono_en(mono_en),
    .fast_sync(fast_sync), .out_invert(out_invert), .clamp_sel(clamp_sel),
    .rst_timing(rst_timing), .chan_sel(chan_sel), .offs_range(offs_range),
    .offs_val(offs_val), .offs_neg(offs_neg), .gain(gain));

  // reference model state
  logic       m_conv, m_cds, m_mono, m_fast, m_inv, m_rng;
  logic [1:0] m_clamp, m_rtime, m_chan;
  logic [7:0] m_ov [3];
  logic       m_sg [3];
  logic [4:0] m_gn [3];

  string  cur_req = "R1";
  bit     armed = 0;
  bit     done = 0;
  integer quiet_until = 0;
  integer cyc = 0;
  integer checks = 0;
  integer fails = 0;

  function automatic void m_defaults();
    m_conv = 1; m_cds = 1; m_mono = 0; m_fast = 0; m_inv = 0; m_rng = 0;
    m_clamp = 2'b01; m_rtime = 2'b01; m_chan = 2'b00;
    for (int c = 0; c < 3; c++) begin
      m_ov[c] = 8'h00; m_sg[c] = 1'b0; m_gn[c] = 5'h00;
    end
  endfunction

  function automatic void m_write(logic [5:0] a, logic [7:0] d);
    int c = int'(a[1:0]);
    if (a == 6'h04) m_defaults();
    else if (a == 6'h01) begin
      m_conv = d[0]; m_cds = d[1]; m_mono = d[2]; m_fast = d[6];
    end else if (a == 6'h02) m_inv = d[2];
    else if (a == 6'h03) begin
      m_clamp = d[1:0]; m_rtime = d[5:4]; m_chan = d[7:6];
    end else if (a == 6'h05) m_rng = d[0];
    else if (a >= 6'h20 && a <= 6'h2B) begin
      for (int k = 0; k < 3; k++) begin
        if (c == 3 || c == k) begin
          if (a[3:2] == 2'b00) m_ov[k] = d;
          else if (a[3:2] == 2'b01) m_sg[k] = d[0];
          else m_gn[k] = d[4:0];
        end
      end
    end
  endfunction

  function automatic logic [53:0] exp_vec();
    return {m_conv, m_cds, m_mono, m_fast, m_inv, m_clamp, m_rtime, m_chan, m_rng,
            m_ov[2], m_ov[1], m_ov[0], m_sg[2], m_sg[1], m_sg[0],
            m_gn[2], m_gn[1], m_gn[0]};
  endfunction

  logic [53:0] act_vec;
  assign act_vec = {conv_en, cds_en, mono_en, fast_sync, out_invert, clamp_sel,
                    rst_timing, chan_sel, offs_range, offs_val, offs_neg, gain};

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end else if (cyc > 150000) begin
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails + 1);
      $finish;
    end else if (armed && cyc >= quiet_until) begin
      checks <= checks + 1;
      if (act_vec !== exp_vec()) begin
        fails <= fails + 1;
        $display("FAIL %s: actual %h expected %h", cur_req, act_vec, exp_vec());
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_bits(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      tick(2);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
      tick(2);
    end
  endtask

  task automatic strobe(bit apply, logic [5:0] a, logic [7:0] d);
    ser_load = 1'b1;
    if (apply) m_write(a, d);
    quiet_until = cyc + 6;
    tick(3);
    ser_load = 1'b0;
    tick(3);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    send_bits({2'b00, a, d}, 14);
    strobe(1, a, d);
  endtask

  initial begin
    m_defaults();
    tick(3);
    arst_n = 1'b1;
    tick(4);
    armed = 1;
    tick(4);

    cur_req = "R3"; wr(6'h01, 8'h44); tick(4);
    cur_req = "R4"; wr(6'h02, 8'hFB); wr(6'h02, 8'h04); tick(4);
    cur_req = "R5"; wr(6'h03, 8'hE6); tick(4);
    cur_req = "R6"; wr(6'h05, 8'h01); tick(4);
    cur_req = "R7";
    wr(6'h20, 8'h5A); wr(6'h21, 8'hA5); wr(6'h22, 8'hFF);
    wr(6'h24, 8'h01); wr(6'h25, 8'hFE); wr(6'h26, 8'h03);
    wr(6'h28, 8'hFF); wr(6'h29, 8'h0A); wr(6'h2A, 8'h13);
    cur_req = "R8"; wr(6'h23, 8'h3C); wr(6'h27, 8'h01); wr(6'h2B, 8'h07);
    cur_req = "R10"; wr(6'h31, 8'h00); wr(6'h3B, 8'h1E); wr(6'h14, 8'h00);
    cur_req = "R12"; wr(6'h00, 8'hFF); wr(6'h06, 8'hFF); wr(6'h2C, 8'h00);
    cur_req = "R11";
    send_bits(16'h01FF, 9);
    strobe(0, 6'h00, 8'h00);
    wr(6'h28, 8'h05);
    cur_req = "R2";
    send_bits(16'h0003, 2);
    wr(6'h29, 8'h16);
    // strobe and next frame's first bit land in the same cycle
    cur_req = "R11";
    send_bits({2'b00, 6'h29, 8'h11}, 14);
    ser_dat = 1'b1;
    tick(2);
    ser_load = 1'b1;
    ser_clk  = 1'b1;
    m_write(6'h29, 8'h11);
    quiet_until = cyc + 6;
    tick(3);
    ser_load = 1'b0;
    ser_clk  = 1'b0;
    tick(2);
    send_bits({3'b000, 5'b01010, 8'h02}, 13);
    strobe(1, 6'h2A, 8'h02);
    cur_req = "R9"; wr(6'h04, 8'hA7); tick(6);
    done = 1;
  end
endmodule